// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the timing for a serial audio link from one source clock. An optional prescaler turns the source clock into a root-clock enable. The root clock is counted so that one sample period lasts a chosen number of root ticks. A bit clock and a left/right frame clock are derived from that count. The frame clock is low for the left channel and high for the right channel. The bit clock makes a chosen number of cycles per sample. When the root count is not a whole multiple of twice the bit count, the bit-clock half periods are spread evenly over the sample period, with no leftover root ticks gathered in one place.

In master mode the block drives the bit and frame clocks and raises an output enable. In slave mode an external codec drives those clocks. The block then keeps its own counters at the start of a frame and only reports the level of the external frame clock, after synchronising it to the source clock. Software reads a left/right index status to line up with a channel before it starts a data path. A ratio change never cuts a frame short. The new ratios take effect at the next sample boundary.

Top module: `audio_clk_gen`

## Requirements
- R1: `root_sel_i` sets the number of root ticks per sample period: 00=256, 01=384, 10=512, 11=768. One frame therefore lasts root ticks × (divide value + 1) source cycles, where the divide value is the prescaler value when the prescaler is enabled and 0 when it is disabled.
- R2: `bck_sel_i` sets the number of bit-clock cycles per sample period: 00=16, 01=32, 10=48, with 11 treated as 32. `bclk_o` is low at the start of every frame and changes only on a root tick.
- R3: Every bit-clock half period is either the floor or the ceiling of (root ticks / (2 × bit cycles)) root ticks long. When that ratio is whole, all half periods are equal.
- R4: `lrck_o` is low for the first half of the frame and high for the second half. Each half holds exactly half of the bit cycles, and each half lasts half of the frame. `lrck_o` changes only on a falling edge of `bclk_o`.
- R5: `ps_cfg_i` bit 0 enables the prescaler, and bits [8 +: PRE_W] hold the divide value. When the prescaler is enabled, `root_tick_o` is a one-cycle pulse every (value + 1) source cycles.
- R6: When the prescaler is disabled, `root_tick_o` is high on every cycle and the divide value has no effect.
- R7: `sample_bits_o` reports the sample width that goes with the active bit ratio: 8 for 16 cycles, 16 for 32 cycles and 24 for 48 cycles.
- R8: A change of `root_sel_i` or `bck_sel_i` in the middle of a frame leaves that frame at its old length and bit count. The new ratios apply from the next frame.
- R9: While `slave_i` is high, `clk_oe_o`, `bclk_o` and `lrck_o` are low and the counters wait at a frame start. After a return to master mode, whole, correct frames are produced.
- R10: `lr_index_o` equals `lrck_o` in master mode. In slave mode it follows `ext_lrck_i` with a latency of exactly two clock edges.
- R11: During and straight after reset, `bclk_o`, `lrck_o` and `lr_index_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_i | input | 1 | 1 = bit and frame clocks come from an external codec |
| ps_cfg_i | input | 8+PRE_W | Prescaler word: bit 0 is the enable, bits [8 +: PRE_W] are the divide value |
| root_sel_i | input | 2 | Root ticks per sample select |
| bck_sel_i | input | 2 | Bit cycles per sample select |
| ext_lrck_i | input | 1 | External frame clock, used in slave mode |
| root_tick_o | output | 1 | Root-clock enable pulse |
| bclk_o | output | 1 | Bit clock level |
| lrck_o | output | 1 | Frame clock level (low = left) |
| clk_oe_o | output | 1 | High when this block drives the bit and frame clocks |
| lr_index_o | output | 1 | Left/right index status |
| sample_bits_o | output | 5 | Sample width paired with the active bit ratio |

## Verification
The bench measures whole frames edge by edge. Pairs of ratios such as 256/48 and 512/48 do not divide evenly, so a generator with naive integer division would drop or add bit cycles per frame, or bunch the leftover ticks into one long half period. The bench checks the spread of half periods against a one-tick tolerance. It changes the selects partway through a frame, which would expose a design that applies ratios at once and produces a short, glitched frame. It also runs with the prescaler disabled but a non-zero value loaded, which catches a design that divides anyway. Slave mode is checked for exact two-edge synchronisation latency, and for a clean restart when the block returns to master.

// File: rtl/asc_pkg.sv
package asc_pkg;
    localparam int POS_W = 10;
    localparam int ACC_W = POS_W + 1;
    localparam int BCK_W = 6;

    typedef logic [1:0] sel_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [ACC_W-1:0] acc;
        logic             bclk;
        logic             lrck;
        sel_t             root_act;
        sel_t             bck_act;
    } frame_st_t;

    function automatic logic [POS_W-1:0] root_len(input sel_t s);
        case (s)
            2'd0:    return POS_W'(256);
            2'd1:    return POS_W'(384);
            2'd2:    return POS_W'(512);
            default: return POS_W'(768);
        endcase
    endfunction

    function automatic logic [BCK_W-1:0] bck_len(input sel_t s);
        case (s)
            2'd0:    return BCK_W'(16);
            2'd2:    return BCK_W'(48);
            default: return BCK_W'(32);
        endcase
    endfunction

    function automatic logic [4:0] width_of(input sel_t s);
        case (s)
            2'd0:    return 5'd8;
            2'd2:    return 5'd24;
            default: return 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/asc_prescaler.sv
module asc_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = !en_i || (cnt_q >= div_i);
        cnt_d  = tick_o ? '0 : cnt_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && $past(tick_o) && $past(div_i) != '0 && $stable(div_i)) |-> !tick_o)
        else $error("tick_gap_chk");
endmodule

// File: rtl/asc_frame_gen.sv
module asc_frame_gen
    import asc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  sel_t root_sel_i,
    input  sel_t bck_sel_i,
    output logic bclk_o,
    output logic lrck_o,
    output logic [4:0] sample_bits_o
);
    frame_st_t st_d, st_q;
    sel_t root_eff, bck_eff;
    logic [POS_W-1:0] rlen;
    logic [ACC_W-1:0] step, sum;

    always_comb begin
        st_d     = st_q;
        root_eff = (st_q.pos == '0) ? root_sel_i : st_q.root_act;
        bck_eff  = (st_q.pos == '0) ? bck_sel_i  : st_q.bck_act;
        rlen     = root_len(root_eff);
        step     = ACC_W'({bck_len(bck_eff), 1'b0});
        sum      = st_q.acc + step;
        if (!run_i) begin
            st_d          = '0;
            st_d.root_act = root_sel_i;
            st_d.bck_act  = bck_sel_i;
        end else if (tick_i) begin
            st_d.root_act = root_eff;
            st_d.bck_act  = bck_eff;
            if (st_q.pos == rlen - POS_W'(1)) begin
                st_d.pos  = '0;
                st_d.acc  = '0;
                st_d.bclk = 1'b0;
            end else begin
                st_d.pos = st_q.pos + POS_W'(1);
                if (sum >= ACC_W'(rlen)) begin
                    st_d.acc  = sum - ACC_W'(rlen);
                    st_d.bclk = !st_q.bclk;
                end else begin
                    st_d.acc  = sum;
                end
            end
            st_d.lrck = (st_d.pos >= (rlen >> 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o        = st_q.bclk;
    assign lrck_o        = st_q.lrck;
    assign sample_bits_o = width_of(st_q.bck_act);

    // R2
    bclk_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(st_q.bclk))
        else $error("bclk_stable_chk");

    // R4
    lrck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_i) && st_q.lrck != $past(st_q.lrck)) |-> ($past(st_q.bclk) && !st_q.bclk))
        else $error("lrck_edge_chk");

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos < root_len(st_q.root_act))
        else $error("pos_range_chk");
endmodule

// File: rtl/asc_lr_sync.sv
module asc_lr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[0], async_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[1];
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
    import asc_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_i,
    input  logic [8+PRE_W-1:0] ps_cfg_i,
    input  logic [1:0]       root_sel_i,
    input  logic [1:0]       bck_sel_i,
    input  logic             ext_lrck_i,
    output logic             root_tick_o,
    output logic             bclk_o,
    output logic             lrck_o,
    output logic             clk_oe_o,
    output logic             lr_index_o,
    output logic [4:0]       sample_bits_o
);
    localparam int DIV_LSB = 8;

    logic tick, lr_sync, lrck_int;

    asc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ps_cfg_i[0]),
        .div_i  (ps_cfg_i[DIV_LSB +: PRE_W]),
        .tick_o (tick)
    );

    asc_frame_gen u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (!slave_i),
        .tick_i        (tick),
        .root_sel_i    (root_sel_i),
        .bck_sel_i     (bck_sel_i),
        .bclk_o        (bclk_o),
        .lrck_o        (lrck_int),
        .sample_bits_o (sample_bits_o)
    );

    asc_lr_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_lrck_i),
        .sync_o  (lr_sync)
    );

    assign root_tick_o = tick;
    assign lrck_o      = lrck_int;
    assign clk_oe_o    = !slave_i;
    assign lr_index_o  = slave_i ? lr_sync : lrck_int;

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_i && $past(slave_i)) |-> (!bclk_o && !lrck_o && !clk_oe_o))
        else $error("slave_quiet_chk");
endmodule

// File: tb/audio_clk_gen_bench.sv
module audio_clk_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W = 8;

    logic clk = 0, rst_n = 0, slave = 0, ext_lrck = 0;
    logic [8+PRE_W-1:0] ps_cfg = '0;
    logic [1:0] root_sel = 2'd0, bck_sel = 2'd1;
    logic root_tick, bclk, lrck, oe, lr_idx;
    logic [4:0] sbits;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    audio_clk_gen #(.PRE_W(PRE_W)) u_audio_clk_gen (
        .clk(clk), .rst_n(rst_n), .slave_i(slave), .ps_cfg_i(ps_cfg),
        .root_sel_i(root_sel), .bck_sel_i(bck_sel), .ext_lrck_i(ext_lrck),
        .root_tick_o(root_tick), .bclk_o(bclk), .lrck_o(lrck), .clk_oe_o(oe),
        .lr_index_o(lr_idx), .sample_bits_o(sbits)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] r, input logic [1:0] b, input bit en, input int val);
        @(negedge clk);
        root_sel = r; bck_sel = b;
        ps_cfg = '0; ps_cfg[0] = en; ps_cfg[8 +: PRE_W] = PRE_W'(val);
    endtask

    task automatic measure(input int chg_at, input logic [1:0] nr, input logic [1:0] nb,
                           output int cyc, output int rises, output int rises_lo, output int lo_cyc,
                           output int hmin, output int hmax, output int lrmis);
        logic pl, pb;
        int h, g;
        pl = lrck; g = 0;
        while (1) begin
            @(negedge clk); g++;
            if ((pl && !lrck) || g > 20000) break;
            pl = lrck;
        end
        cyc = 0; rises = 0; rises_lo = 0; lo_cyc = 0; hmin = 1 << 30; hmax = 0; lrmis = 0; h = 0;
        pb = bclk; pl = lrck;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++; h++;
            if (cyc == chg_at) begin root_sel = nr; bck_sel = nb; end
            if (lr_idx !== lrck) lrmis++;
            if (!lrck) lo_cyc++;
            if (bclk !== pb) begin
                if (h < hmin) hmin = h;
                if (h > hmax) hmax = h;
                h = 0;
                if (bclk) begin rises++; if (!lrck) rises_lo++; end
                pb = bclk;
            end
            if (pl && !lrck) break;
            pl = lrck;
        end
    endtask

    task automatic check_frame(input int R, input int B, input int p, input int chg_at,
                               input logic [1:0] nr, input logic [1:0] nb);
        int cyc, rs, rl, lo, hmn, hmx, lm, n, base;
        measure(chg_at, nr, nb, cyc, rs, rl, lo, hmn, hmx, lm);
        n = R * (p + 1);
        base = (R / (2 * B)) * (p + 1);
        chk(cyc == n, "R1 frame length", cyc, n);
        chk(rs == B, "R2 bit cycles per frame", rs, B);
        chk(rl == B / 2, "R4 bit cycles in left half", rl, B / 2);
        chk(lo == n / 2, "R4 left half length", lo, n / 2);
        chk(lm == 0, "R10 index tracks frame clock", lm, 0);
        chk(hmn == base, "R3 shortest half period", hmn, base);
        if (R % (2 * B) == 0) chk(hmx == base, "R3 longest half period", hmx, base);
        else                  chk(hmx == base + p + 1, "R3 longest half period", hmx, base + p + 1);
    endtask

    task automatic t_reset;
        chk(!bclk && !lrck && !lr_idx, "R11 in reset", {bclk, lrck, lr_idx}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(!bclk && !lrck && !lr_idx, "R11 after reset", {bclk, lrck, lr_idx}, 0);
        chk(oe == 1'b1, "R9 master drives clocks", oe, 1);
    endtask

    task automatic t_ratio(input logic [1:0] r, input logic [1:0] b, input int R, input int B, input int bits);
        set_cfg(r, b, 0, 0);
        check_frame(R, B, 0, 0, r, b);
        chk(sbits == 5'(bits), "R7 sample width", sbits, bits);
    endtask

    task automatic t_prescale;
        int cnt, back;
        set_cfg(2'd2, 2'd1, 1, 2);
        cnt = 0; back = 0;
        repeat (30) begin
            @(negedge clk);
            if (root_tick) begin cnt++; if (back) back = 2; else back = 1; end
            else if (back == 1) back = 0;
        end
        chk(cnt == 10, "R5 tick count", cnt, 10);
        chk(back != 2, "R5 ticks are single cycle", back, 0);
        check_frame(512, 32, 2, 0, 2'd2, 2'd1);
    endtask

    task automatic t_bypass;
        int cnt;
        set_cfg(2'd0, 2'd1, 0, 5);
        cnt = 0;
        repeat (20) begin @(negedge clk); if (root_tick) cnt++; end
        chk(cnt == 20, "R6 ticks every cycle", cnt, 20);
        check_frame(256, 32, 0, 0, 2'd0, 2'd1);
    endtask

    task automatic t_change;
        set_cfg(2'd0, 2'd1, 0, 0);
        check_frame(256, 32, 0, 0, 2'd0, 2'd1);
        check_frame(256, 32, 0, 50, 2'd3, 2'd2);
        check_frame(768, 48, 0, 0, 2'd3, 2'd2);
        chk(sbits == 5'd24, "R8 new ratio active", sbits, 24);
    endtask

    task automatic t_slave;
        int bad;
        set_cfg(2'd0, 2'd1, 0, 0);
        @(negedge clk); slave = 1; ext_lrck = 0;
        bad = 0;
        repeat (100) begin @(negedge clk); if (bclk || lrck || oe) bad++; end
        chk(bad == 0, "R9 quiet in slave mode", bad, 0);
        ext_lrck = 1;
        @(negedge clk);
        chk(lr_idx == 1'b0, "R10 one edge after change", lr_idx, 0);
        @(negedge clk);
        chk(lr_idx == 1'b1, "R10 two edges after change", lr_idx, 1);
        ext_lrck = 0;
        @(negedge clk); @(negedge clk);
        chk(lr_idx == 1'b0, "R10 follows low", lr_idx, 0);
        slave = 0;
        check_frame(256, 32, 0, 0, 2'd0, 2'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ratio(2'd0, 2'd1, 256, 32, 16);
        t_ratio(2'd1, 2'd2, 384, 48, 24);
        t_ratio(2'd3, 2'd0, 768, 16, 8);
        t_ratio(2'd0, 2'd2, 256, 48, 24);
        t_ratio(2'd2, 2'd2, 512, 48, 24);
        t_ratio(2'd0, 2'd3, 256, 32, 16);
        t_prescale();
        t_bypass();
        t_change();
        t_slave();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule